// File: doc/BRIEF.md
# SDLC Frame Status Queue

This block records the outcome of every received SDLC/HDLC frame so that a host can check each frame after a DMA engine has already moved its data to memory. A 14-bit counter counts the bytes of the frame in progress. When the frame ends, either on a closing flag or on an abort, the count and the 5-bit status word offered by the receiver are stored together as one 19-bit record. Records go into a 10-deep first-in, first-out queue. The counter restarts at once, so a new frame can begin on the very next byte.

The host reads results through a small byte-wide register window. While queue mode is active, the count registers and the status register show the oldest record, and reading the status register removes that record. Queue mode is active when the enable bit is set and the channel runs in SDLC/HDLC framing. When the queue is empty, or queue mode is off, the status register shows the live receiver status. With queue mode off, the two count addresses mirror the two lower auxiliary registers. A completed frame that finds the queue full is dropped, and a sticky overrun flag records the loss.

Top module: `frame_stat_queue`

## Requirements
- R1: The byte counter increments on each `byte_rx` pulse, saturates at 16383 without wrapping, and clears on `rst` or `chan_rst`.
- R2: A cycle with `frame_end` or `frame_abort` ends the frame. In queue mode it stores {counter value, `live_stat`}. The counter becomes 1 if `byte_rx` is also high in that cycle, otherwise 0.
- R3: The enable bit clears on `rst` and loads `cfg_en` when `cfg_we` is high. It reads back at address 15, bit 2. Queue mode = enable AND `sdlc_mode`.
- R4: With queue mode off, address 1 returns {3'b0, `live_stat`}, addresses 6 and 7 return `aux_lo` and `aux_hi` (the values of addresses 2 and 3), and the queue stays empty.
- R5: In queue mode with the queue non-empty, address 6 returns the oldest count bits 7:0, address 7 returns {2'b0, count bits 13:8}, and address 1 returns {3'b0, status}. A cycle with `rd_en` at address 1 removes the oldest record; reads at 6 or 7 remove nothing.
- R6: In queue mode with the queue empty, address 1 returns the live status and addresses 6/7 return the running counter in the same split. A status read then removes nothing (no underflow).
- R7: Records are returned in arrival order, and up to 10 are held.
- R8: A frame end that finds 10 records stored, with no removal in the same cycle, is discarded without touching the stored records. It sets a sticky overrun flag, read at address 15, bit 7.
- R9: `rst`, `chan_rst` or queue mode being off empties the queue and clears the overrun flag.
- R10: A frame end and a status-read removal in the same cycle both take effect, leaving the occupancy unchanged, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| sdlc_mode | input | 1 | Channel runs SDLC/HDLC framing |
| byte_rx | input | 1 | One received data byte |
| frame_end | input | 1 | Closing flag of a frame seen |
| frame_abort | input | 1 | Frame terminated by abort |
| live_stat | input | 5 | Live receiver status word |
| aux_lo | input | 8 | Contents of auxiliary register 2 |
| aux_hi | input | 8 | Contents of auxiliary register 3 |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_en | input | 1 | Value written to the enable bit |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 8 | Read data, combinational from address and state |

## Verification
Read data is combinational, so it is due in the same cycle as the address. A push, a pop, a counter step, a change of the enable bit or an overrun becomes visible only after the next rising edge. The bench drives inputs on the falling edge and compares `rd_data` one time unit later, before the rising edge that applies the cycle. It advances its reference model only after that edge, so each comparison reflects exactly the strobes of earlier cycles. Directed cycles place a push and a pop in the same cycle, fill the queue past ten records, and run the counter into saturation, sampling one cycle after the causing strobe.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int CNT_W  = 14;
    localparam int STAT_W = 5;
    localparam int QDEPTH = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [STAT_W-1:0] stat;
    } frame_rec_t;

    localparam int REC_W = $bits(frame_rec_t);

    typedef enum logic [ADDR_W-1:0] {
        A_STAT   = 4'd1,
        A_AUX_LO = 4'd2,
        A_AUX_HI = 4'd3,
        A_CNT_LO = 4'd6,
        A_CNT_HI = 4'd7,
        A_CTRL   = 4'd15
    } reg_addr_t;

    localparam int CTRL_EN_BIT  = 2;
    localparam int CTRL_OVR_BIT = 7;

    function automatic logic [DATA_W-1:0] stat_byte(input logic [STAT_W-1:0] s);
        return {{(DATA_W-STAT_W){1'b0}}, s};
    endfunction

    function automatic logic [DATA_W-1:0] count_lo(input logic [CNT_W-1:0] c);
        return c[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] count_hi(input logic [CNT_W-1:0] c);
        return {{(2*DATA_W-CNT_W){1'b0}}, c[CNT_W-1:DATA_W]};
    endfunction

endpackage

// File: rtl/sfs_byte_counter.sv
module sfs_byte_counter #(
    parameter int W = sfs_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         byte_rx,
    input  logic         frame_done,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (frame_done) begin
            cnt <= byte_rx ? W'(1) : '0;
        end else if (byte_rx && (cnt != CNT_MAX)) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/sfs_rec_queue.sv
module sfs_rec_queue #(
    parameter int DEPTH = sfs_pkg::QDEPTH,
    parameter int W     = sfs_pkg::REC_W
) (
    input  logic                          clk,
    input  logic                          clr,
    input  logic                          push,
    input  logic                          pop,
    input  logic [W-1:0]                  wdata,
    output logic [W-1:0]                  head,
    output logic                          empty,
    output logic                          full,
    output logic                          ovr,
    output logic [$clog2(DEPTH+1)-1:0]    occ
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH+1);
    localparam logic [OCC_W-1:0] DEPTH_V = OCC_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH-1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop_ok, push_ok, drop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_P) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (occ == '0);
    assign full    = (occ == DEPTH_V);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign drop    = push && full && !pop_ok;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            ovr    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      occ <= occ + OCC_W'(1);
            else if (pop_ok && !push_ok) occ <= occ - OCC_W'(1);
            if (drop) ovr <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!clr && push_ok) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/sfs_read_mux.sv
module sfs_read_mux
    import sfs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              qmode,
    input  logic              empty,
    input  frame_rec_t        head,
    input  logic [STAT_W-1:0] live_stat,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic [DATA_W-1:0] aux_lo,
    input  logic [DATA_W-1:0] aux_hi,
    input  logic              en,
    input  logic              ovr,
    output logic [DATA_W-1:0] rd_data
);
    logic             from_q;
    logic [CNT_W-1:0] cnt_sel;

    assign from_q  = qmode && !empty;
    assign cnt_sel = from_q ? head.count : live_cnt;

    always_comb begin
        rd_data = '0;
        case (addr)
            A_STAT:   rd_data = stat_byte(from_q ? head.stat : live_stat);
            A_AUX_LO: rd_data = aux_lo;
            A_AUX_HI: rd_data = aux_hi;
            A_CNT_LO: rd_data = qmode ? count_lo(cnt_sel) : aux_lo;
            A_CNT_HI: rd_data = qmode ? count_hi(cnt_sel) : aux_hi;
            A_CTRL: begin
                rd_data[CTRL_EN_BIT]  = en;
                rd_data[CTRL_OVR_BIT] = ovr;
            end
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/frame_stat_queue.sv
module frame_stat_queue
    import sfs_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_rst,
    input  logic              sdlc_mode,
    input  logic              byte_rx,
    input  logic              frame_end,
    input  logic              frame_abort,
    input  logic [STAT_W-1:0] live_stat,
    input  logic [DATA_W-1:0] aux_lo,
    input  logic [DATA_W-1:0] aux_hi,
    input  logic              cfg_we,
    input  logic              cfg_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int OCC_W = $clog2(DEPTH+1);

    logic             en, qmode, q_clr, frame_done, push, pop;
    logic             empty, full, ovr;
    logic [OCC_W-1:0] occ;
    logic [CNT_W-1:0] cnt;
    frame_rec_t       wrec, head;

    always_ff @(posedge clk) begin
        if (rst)         en <= 1'b0;
        else if (cfg_we) en <= cfg_en;
    end

    assign qmode      = en && sdlc_mode;
    assign q_clr      = rst || chan_rst || !qmode;
    assign frame_done = frame_end || frame_abort;
    assign push       = qmode && frame_done;
    assign pop        = qmode && rd_en && (rd_addr == A_STAT);
    assign wrec       = '{count: cnt, stat: live_stat};

    sfs_byte_counter #(.W(CNT_W)) cnt_i (
        .clk        (clk),
        .clr        (rst || chan_rst),
        .byte_rx    (byte_rx),
        .frame_done (frame_done),
        .cnt        (cnt)
    );

    sfs_rec_queue #(.DEPTH(DEPTH), .W(REC_W)) q_i (
        .clk   (clk),
        .clr   (q_clr),
        .push  (push),
        .pop   (pop),
        .wdata (wrec),
        .head  (head),
        .empty (empty),
        .full  (full),
        .ovr   (ovr),
        .occ   (occ)
    );

    sfs_read_mux mux_i (
        .addr      (rd_addr),
        .qmode     (qmode),
        .empty     (empty),
        .head      (head),
        .live_stat (live_stat),
        .live_cnt  (cnt),
        .aux_lo    (aux_lo),
        .aux_hi    (aux_hi),
        .en        (en),
        .ovr       (ovr),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
    parameter int DEPTH = sfs_pkg::QDEPTH,
    parameter int CW    = sfs_pkg::CNT_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       en,
    input logic                       q_clr,
    input logic                       push,
    input logic                       pop,
    input logic                       empty,
    input logic                       full,
    input logic                       ovr,
    input logic [$clog2(DEPTH+1)-1:0] occ,
    input logic [CW-1:0]              cnt,
    input logic                       byte_rx,
    input logic                       frame_done
);
    localparam int OCC_W = $clog2(DEPTH+1);
    localparam logic [OCC_W-1:0] DEPTH_V = OCC_W'(DEPTH);
    localparam logic [CW-1:0]    CMAX    = {CW{1'b1}};

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= DEPTH_V);

    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!q_clr && push && full && !pop) |=> ovr);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && !q_clr) |=> ovr);

    // R9
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        q_clr |=> (empty && !ovr));

    // R10
    push_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (!q_clr && push && pop && !empty) |=> (occ == $past(occ)));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> empty);

    // R1
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CMAX && byte_rx && !frame_done) |=> (cnt == CMAX));

    // R2
    frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !byte_rx) |=> (cnt == '0));

    // R3
    en_reset_chk: assert property (@(posedge clk)
        rst |=> !en);
endmodule

bind frame_stat_queue sfs_checker #(.DEPTH(DEPTH), .CW(sfs_pkg::CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .q_clr      (q_clr),
    .push       (push),
    .pop        (pop),
    .empty      (empty),
    .full       (full),
    .ovr        (ovr),
    .occ        (occ),
    .cnt        (cnt),
    .byte_rx    (byte_rx),
    .frame_done (frame_done)
);

// File: tb/frame_stat_queue_tb_top.sv
module frame_stat_queue_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QD         = 10;
    localparam int CMAXV      = 16383;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst, chan_rst, sdlc_mode, byte_rx, frame_end, frame_abort;
    logic [4:0] live_stat;
    logic [7:0] aux_lo, aux_hi;
    logic       cfg_we, cfg_en, rd_en;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    bit          m_en, m_ovr;
    int          m_cnt;
    logic [18:0] q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_stat_queue dut_i (
        .clk(clk), .rst(rst), .chan_rst(chan_rst), .sdlc_mode(sdlc_mode),
        .byte_rx(byte_rx), .frame_end(frame_end), .frame_abort(frame_abort),
        .live_stat(live_stat), .aux_lo(aux_lo), .aux_hi(aux_hi),
        .cfg_we(cfg_we), .cfg_en(cfg_en), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    function automatic bit qm();
        return m_en && sdlc_mode;
    endfunction

    function automatic logic [7:0] exp_rd();
        logic [13:0] c;
        bit fq;
        fq = qm() && (q.size() > 0);
        c  = fq ? q[0][18:5] : 14'(m_cnt);
        case (rd_addr)
            4'd1:  return fq ? {3'b0, q[0][4:0]} : {3'b0, live_stat};
            4'd2:  return aux_lo;
            4'd3:  return aux_hi;
            4'd6:  return qm() ? c[7:0] : aux_lo;
            4'd7:  return qm() ? {2'b0, c[13:8]} : aux_hi;
            4'd15: return {m_ovr, 4'b0, m_en, 2'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string auto_tag();
        if (rd_addr == 4'd15) return m_ovr ? "R8" : "R3";
        if (!qm()) return "R4";
        if (rd_addr == 4'd1 || rd_addr == 4'd6 || rd_addr == 4'd7)
            return (q.size() > 0) ? "R5" : "R6";
        return "R4";
    endfunction

    task automatic model_update();
        bit pop, dn;
        dn = frame_end || frame_abort;
        if (rst) begin
            m_en = 0; m_cnt = 0; m_ovr = 0; q.delete();
        end else begin
            if (chan_rst || !qm()) begin
                q.delete(); m_ovr = 0;
            end else begin
                pop = rd_en && rd_addr == 4'd1 && q.size() > 0;
                if (dn && q.size() == QD && !pop) m_ovr = 1;
                if (pop) void'(q.pop_front());
                if (dn && (q.size() < QD)) q.push_back({14'(m_cnt), live_stat});
            end
            if (chan_rst) m_cnt = 0;
            else if (dn) m_cnt = byte_rx ? 1 : 0;
            else if (byte_rx && m_cnt < CMAXV) m_cnt++;
            if (cfg_we) m_en = cfg_en;
        end
    endtask

    task automatic tick(input string tag = "");
        logic [7:0] e;
        string t;
        #1;
        e = exp_rd();
        t = (tag == "") ? auto_tag() : tag;
        n_tests++;
        if (rd_data !== e) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", t, rd_addr, rd_data, e);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 0; chan_rst = 0; byte_rx = 0; frame_end = 0; frame_abort = 0;
        cfg_we = 0; rd_en = 0;
    endtask

    task automatic set_en(input bit v);
        cfg_we = 1; cfg_en = v; tick("R3"); cfg_we = 0;
    endtask

    task automatic send_frame(input int nbytes, input logic [4:0] st, input bit ab);
        for (int i = 0; i < nbytes; i++) begin
            byte_rx = 1; rd_addr = 4'd6; tick("R1");
        end
        byte_rx = 0; live_stat = st;
        if (ab) frame_abort = 1; else frame_end = 1;
        tick("R2");
        frame_end = 0; frame_abort = 0;
    endtask

    task automatic pop_one(input string tag);
        rd_en = 1; rd_addr = 4'd6; tick(tag);
        rd_addr = 4'd7; tick(tag);
        rd_addr = 4'd1; tick(tag);
        rd_en = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'h5EED_0C3A);
        idle();
        sdlc_mode = 1; live_stat = 5'h00; aux_lo = 8'hA5; aux_hi = 8'h5A;
        cfg_en = 0; rd_addr = 4'd15;
        @(negedge clk);
        rst = 1; tick("R3"); tick("R3"); rst = 0;
        tick("R3");

        // R4: bypass mode mirrors and live status
        live_stat = 5'h13;
        rd_addr = 4'd6; tick("R4");
        rd_addr = 4'd7; tick("R4");
        rd_addr = 4'd1; rd_en = 1; tick("R4"); rd_en = 0;
        send_frame(2, 5'h01, 0);
        rd_addr = 4'd1; tick("R4");

        // R3: enable and read back
        set_en(1);
        rd_addr = 4'd15; tick("R3");

        // R7/R8: fill ten, then overrun
        for (int f = 0; f < QD; f++) send_frame(f + 3, 5'(f + 1), f[0]);
        rd_addr = 4'd15; tick("R7");
        send_frame(4, 5'h1F, 0);
        rd_addr = 4'd15; tick("R8");
        for (int f = 0; f < QD; f++) pop_one("R7");
        live_stat = 5'h0E;
        rd_addr = 4'd1; rd_en = 1; tick("R6"); tick("R6"); rd_en = 0;
        rd_addr = 4'd6; tick("R6");
        rd_addr = 4'd15; tick("R8");

        // R10: push and pop in the same cycle
        send_frame(5, 5'h07, 0);
        byte_rx = 1; tick("R10"); byte_rx = 0;
        frame_end = 1; live_stat = 5'h09; rd_en = 1; rd_addr = 4'd1; tick("R10");
        frame_end = 0; rd_en = 0;
        rd_addr = 4'd6; tick("R10");
        rd_addr = 4'd1; tick("R10");
        pop_one("R10");
        rd_addr = 4'd1; live_stat = 5'h02; tick("R10");
        // R10 at full occupancy
        for (int f = 0; f < QD; f++) send_frame(1, 5'(f), 0);
        frame_end = 1; live_stat = 5'h15; rd_en = 1; rd_addr = 4'd1; tick("R10");
        frame_end = 0; rd_en = 0;
        rd_addr = 4'd15; tick("R10");

        // R9: channel reset and mode loss clear the queue
        send_frame(3, 5'h04, 0);
        chan_rst = 1; tick("R9"); chan_rst = 0;
        rd_addr = 4'd1; tick("R9");
        rd_addr = 4'd15; tick("R9");
        for (int f = 0; f < QD + 1; f++) send_frame(1, 5'h03, 0);
        rd_addr = 4'd15; tick("R8");
        sdlc_mode = 0; tick("R9"); sdlc_mode = 1;
        rd_addr = 4'd15; tick("R9");
        rd_addr = 4'd1; tick("R9");

        // R1: saturation of the byte counter
        rd_addr = 4'd6;
        for (int i = 0; i < CMAXV + 6; i++) begin
            byte_rx = 1; tick("R1");
        end
        rd_addr = 4'd7; tick("R1");
        byte_rx = 0; frame_end = 1; tick("R1"); frame_end = 0;
        rd_addr = 4'd6; tick("R1");
        rd_addr = 4'd7; tick("R1");
        pop_one("R1");

        // Random traffic
        for (int i = 0; i < 20000; i++) begin
            logic [3:0] addrs [7];
            addrs = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd6, 4'd7, 4'd15};
            rst         = ($urandom_range(0, 4999) == 0);
            chan_rst    = ($urandom_range(0, 1499) == 0);
            sdlc_mode   = ($urandom_range(0, 199) != 0);
            cfg_we      = ($urandom_range(0, 299) == 0);
            cfg_en      = ($urandom_range(0, 3) != 0);
            byte_rx     = ($urandom_range(0, 9) < 6);
            frame_end   = ($urandom_range(0, 19) == 0);
            frame_abort = ($urandom_range(0, 49) == 0);
            live_stat   = 5'($urandom);
            aux_lo      = 8'($urandom);
            aux_hi      = 8'($urandom);
            rd_en       = ($urandom_range(0, 1) == 1);
            rd_addr     = addrs[$urandom_range(0, 6)];
            tick();
            if (!m_en && $urandom_range(0, 49) == 0) begin
                idle(); set_en(1);
            end
        end
        idle();
        tick();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule